// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Selects

This block connects a clocked host to an asynchronous static RAM that is 2M words deep and 32 bits wide. The RAM has one active-low chip select per byte, plus a write enable and an output enable that all bytes share. The host offers one word access at a time through a valid/ready handshake. Each request carries an address, write data, a write flag and a 4-bit byte mask. The controller turns the request into strobe sequences whose lengths are whole numbers of clock cycles. Every read ends with a one-cycle done pulse that carries the captured word. A write also ends with a done pulse, and its read-data value is not meaningful.

Every timing parameter is given in nanoseconds, together with the clock period. The controller rounds each one up to a cycle count. For a write, the address, the byte selects and the data are set up first. Write enable then pulses low, and everything is held for one more cycle. For a read, the selected bytes and output enable are held low for the read window, and the word is sampled on the last edge of that window. After a read, the data bus stays undriven long enough for the RAM outputs to float. The RAM data pins are split into an output word, a drive enable and an input word, and the tri-state pad sits outside this block.

Top module: `sram_byte_ctrl`

## Requirements
- R1: During and right after reset: `req_ready`=1, `mem_cs_n`=4'hF, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rsp_done`=0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. Call the cycle after that edge cycle 1. `req_ready` is 0 from cycle 1 until the access completes. For a write, `rsp_done` and `req_ready` both reach 1 in cycle NPULSE+3. For a read, `rsp_done` is 1 in cycle NRD+1 and `req_ready` returns in cycle NRD+NTA+1.
- R3: Bit i of `req_mask` covers data bits 8i+7..8i. For the whole access, `mem_cs_n[i]` is low exactly when mask bit i is 1; the other selects stay high.
- R4: For a write, the address, the selects and `mem_dq_out` = write data (with `mem_dq_oe`=1) appear one cycle before `mem_we_n` falls. `mem_we_n` then stays low for exactly NPULSE cycles. All of them are held one cycle after `mem_we_n` rises. `mem_oe_n` stays high throughout.
- R5: `mem_addr` and `mem_cs_n` change only while `mem_we_n` is high. Both equal the request's values in every cycle of the access in which any select is low.
- R6: For a read, `mem_we_n` stays high and `mem_oe_n` is low for exactly NRD cycles, with the selects low. The word on `mem_dq_in` is sampled at the edge that ends the last of those cycles and returned on `rsp_rdata` with `rsp_done`. The bytes whose selects were high read as zero.
- R7: After `mem_oe_n` rises at the end of a read, `mem_dq_oe` stays 0 for at least NTA cycles.
- R8: `mem_dq_oe` is 1 only during write accesses, and never while `mem_oe_n` is 0.
- R9: Each duration becomes ceil(ns / clock period), with a minimum of 1. NPULSE is the largest of: the write-enable width, the data setup, the select-to-end time minus 1, and the write cycle minus 2. NRD is the largest of the read cycle, the address-to-data time and the enable-to-data time. NTA is the write-enable-to-float time. With the default parameters and a 10 ns clock, NPULSE=2, NRD=2 and NTA=2.
- R10: `rsp_done` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 21 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte mask, bit i for byte i |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Captured read word, unselected bytes zero |
| mem_addr | output | 21 | RAM address |
| mem_cs_n | output | 4 | Per-byte chip selects, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 32 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 32 | Data arriving from the RAM |

## Verification
The bench sends a read right behind a write, and a write right behind a read. A controller that drops the float time after a read would turn its data drivers on while the RAM is still driving the bus. A controller with a miscounted strobe window would finish early or late. The bench also writes single bytes and reads with partial masks over known contents. A lane whose select is wrongly asserted would corrupt a neighbouring byte, and a lane that is not zeroed would return floating bus junk. Finally, it measures the setup and hold cycles around each write-enable pulse, which catches an address or select that moves during the pulse.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ,
    ST_TURN
  } ctl_state_t;

  // Round a nanosecond duration up to whole clock cycles, never below one.
  function automatic int ns2cyc(input int dur_ns, input int period_ns);
    int c;
    c = (dur_ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_down_cnt.sv
module sram_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         at_zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign at_zero = (cnt == '0);

  // R9: a loaded count never grows without a new load
  p_cnt_down_r9: assert property (@(posedge clk) disable iff (rst)
    !load && $past(!load) && $past(cnt) != '0 |-> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          open_sel,
  input  logic          sel_bit,
  input  logic          close_sel,
  input  logic          capture,
  input  logic [LW-1:0] din,
  output logic          cs_n,
  output logic [LW-1:0] rbyte
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n  <= 1'b1;
      rbyte <= '0;
    end else begin
      if (open_sel)
        cs_n <= ~sel_bit;
      else if (close_sel)
        cs_n <= 1'b1;
      if (capture)
        rbyte <= cs_n ? '0 : din;
    end
  end

  // R6: a lane that was not selected returns zero
  p_lane_zero_r6: assert property (@(posedge clk) disable iff (rst)
    capture && cs_n |=> rbyte == '0);

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int NBYTES     = 4,
  parameter int LANE_W     = 8,
  parameter int CLK_NS     = 10,
  parameter int T_WC_NS    = 20,
  parameter int T_PWE_NS   = 15,
  parameter int T_AW_NS    = 17,
  parameter int T_SD_NS    = 12,
  parameter int T_RC_NS    = 20,
  parameter int T_AA_NS    = 20,
  parameter int T_DOE_NS   = 12,
  parameter int T_HZWE_NS  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [NBYTES*LANE_W-1:0] req_wdata,
  input  logic [NBYTES-1:0]        req_mask,
  output logic                     rsp_done,
  output logic [NBYTES*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [NBYTES-1:0]        mem_cs_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [NBYTES*LANE_W-1:0] mem_dq_out,
  output logic                     mem_dq_oe,
  input  logic [NBYTES*LANE_W-1:0] mem_dq_in
);

  localparam int NPULSE = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
                               imax(ns2cyc(T_AW_NS, CLK_NS) - 1, ns2cyc(T_WC_NS, CLK_NS) - 2));
  localparam int NRD    = imax(ns2cyc(T_RC_NS, CLK_NS),
                               imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_DOE_NS, CLK_NS)));
  localparam int NTA    = ns2cyc(T_HZWE_NS, CLK_NS);
  localparam int NMAX   = imax(NPULSE, imax(NRD, NTA));
  localparam int CW     = $clog2(NMAX) + 1;

  ctl_state_t      state;
  logic            cnt_load;
  logic [CW-1:0]   cnt_val;
  logic            cnt_zero;
  logic            accept;
  logic            lane_open;
  logic            lane_close;
  logic            lane_cap;

  assign accept     = (state == ST_IDLE) && req_valid;
  assign lane_open  = accept;
  assign lane_cap   = (state == ST_READ) && cnt_zero;
  assign lane_close = (state == ST_WHOLD) || lane_cap;

  // Counter reload points: read window at accept, pulse at setup, float time at read end
  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (accept && !req_write) begin
      cnt_load = 1'b1;
      cnt_val  = CW'(NRD - 1);
    end else if (state == ST_WSETUP) begin
      cnt_load = 1'b1;
      cnt_val  = CW'(NPULSE - 1);
    end else if (lane_cap) begin
      cnt_load = 1'b1;
      cnt_val  = CW'(NTA - 1);
    end
  end

  sram_down_cnt #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .at_zero  (cnt_zero)
  );

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    sram_byte_lane #(.LW(LANE_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .open_sel  (lane_open),
      .sel_bit   (req_mask[i]),
      .close_sel (lane_close),
      .capture   (lane_cap),
      .din       (mem_dq_in[i*LANE_W +: LANE_W]),
      .cs_n      (mem_cs_n[i]),
      .rbyte     (rsp_rdata[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_ready  <= 1'b1;
      rsp_done   <= 1'b0;
      mem_addr   <= '0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            req_ready  <= 1'b0;
            if (req_write) begin
              mem_dq_oe <= 1'b1;
              state     <= ST_WSETUP;
            end else begin
              mem_oe_n  <= 1'b0;
              state     <= ST_READ;
            end
          end
        end
        ST_WSETUP: begin
          mem_we_n <= 1'b0;
          state    <= ST_WPULSE;
        end
        ST_WPULSE: begin
          if (cnt_zero) begin
            mem_we_n <= 1'b1;
            state    <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          mem_dq_oe <= 1'b0;
          rsp_done  <= 1'b1;
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_READ: begin
          if (cnt_zero) begin
            mem_oe_n <= 1'b1;
            rsp_done <= 1'b1;
            state    <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (cnt_zero) begin
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Assertion support: length of the current write-enable pulse and of the float time
  logic [7:0] we_low_cnt;
  logic [7:0] hz_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_cnt <= '0;
      hz_cnt     <= 8'hFF;
    end else begin
      we_low_cnt <= mem_we_n ? 8'd0 : we_low_cnt + 8'd1;
      if (!mem_oe_n)
        hz_cnt <= '0;
      else if (hz_cnt != 8'hFF)
        hz_cnt <= hz_cnt + 8'd1;
    end
  end

  // R2: no select is active while the host sees ready
  p_busy_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n != '1) |-> !req_ready);

  // R3: selects do not change while any is active
  p_cs_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n != '1) && $past(mem_cs_n != '1) |-> $stable(mem_cs_n));

  // R4: pulse length and output enable off during the pulse
  p_we_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> we_low_cnt == 8'(NPULSE));
  p_we_oe_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n && mem_dq_oe);

  // R5: address and selects steady across the pulse and its hold cycle
  p_addr_we_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> $stable(mem_addr) && $stable(mem_cs_n));
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> $stable(mem_addr) && $stable(mem_cs_n));

  // R6: reads keep write enable high
  p_read_we_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> mem_we_n);

  // R7: drivers wait for the RAM outputs to float
  p_turn_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> hz_cnt >= 8'(NTA));

  // R8: never drive while the RAM drives
  p_no_fight_r8: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

endmodule

// File: tb/sim_sram_byte_ctrl.sv
module sim_sram_byte_ctrl;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + 9) / 10;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NPULSE = mx(mx(cyc(15), cyc(12)), mx(cyc(17) - 1, cyc(20) - 2));
  localparam int NRD    = mx(cyc(20), mx(cyc(20), cyc(12)));
  localparam int NTA    = cyc(12);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [20:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_we_n;
  logic        mem_oe_n;
  logic [31:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [31:0] mem_dq_in;

  int checks = 0;
  int errors = 0;

  logic [31:0] ram  [256];
  logic [31:0] expm [256];

  always #5 clk = ~clk;

  sram_byte_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // RAM model: a byte drives only when selected and output-enabled; otherwise junk
  always_comb begin
    for (int i = 0; i < 4; i++)
      mem_dq_in[i*8 +: 8] = (!mem_cs_n[i] && !mem_oe_n && mem_we_n) ?
                            ram[mem_addr[7:0]][i*8 +: 8] : 8'hA5;
  end

  // Write lands on the rising edge of write enable
  always @(posedge mem_we_n) begin
    if (!rst && mem_dq_oe)
      for (int i = 0; i < 4; i++)
        if (!mem_cs_n[i]) ram[mem_addr[7:0]][i*8 +: 8] <= mem_dq_out[i*8 +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_bytes(input logic [31:0] w, input logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? w[i*8 +: 8] : 8'h00;
    return r;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? d[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  // Turnaround monitor (R7)
  int  gap = 100;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_dq_oe && !prev_oe)
        chk(gap >= NTA, "R7 float cycles before drive", 32'(gap), 32'(NTA));
      gap     = mem_oe_n ? gap + 1 : 0;
      prev_oe = mem_dq_oe;
    end
  end

  // Called at a negedge; returns at the negedge where ready is back
  task automatic access(input bit wr, input logic [20:0] a, input logic [31:0] d, input logic [3:0] m);
    int k, done_k, ready_k, done_n, we_low, oe_low, fcs, fwe, lcs, lwe;
    bit bad_cs, bad_addr, bad_dq, fight;
    logic [31:0] rd;
    logic [31:0] exp_rd;
    done_k = 0; ready_k = 0; done_n = 0; we_low = 0; oe_low = 0;
    fcs = 0; fwe = 0; lcs = 0; lwe = 0;
    bad_cs = 0; bad_addr = 0; bad_dq = 0; fight = 0; rd = '0;
    while (!req_ready) @(negedge clk);
    exp_rd    = mask_bytes(expm[a[7:0]], m);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    for (k = 1; k < 60; k++) begin
      if (mem_cs_n != 4'hF) begin
        if (fcs == 0) fcs = k;
        lcs = k;
        if (mem_cs_n != ~m) bad_cs = 1;
        if (mem_addr != a) bad_addr = 1;
        if (wr && (!mem_dq_oe || mem_dq_out != d)) bad_dq = 1;
      end
      if (!mem_we_n) begin
        we_low++;
        if (fwe == 0) fwe = k;
        lwe = k;
      end
      if (!mem_oe_n) oe_low++;
      if (!mem_oe_n && mem_dq_oe) fight = 1;
      if (!wr && mem_dq_oe) fight = 1;
      if (rsp_done) begin
        done_n++;
        if (done_k == 0) begin done_k = k; rd = rsp_rdata; end
      end
      if (req_ready) begin ready_k = k; break; end
      @(negedge clk);
    end
    chk(done_k == (wr ? NPULSE + 3 : NRD + 1), "R2 R9 done cycle", 32'(done_k), 32'(wr ? NPULSE + 3 : NRD + 1));
    chk(ready_k == (wr ? NPULSE + 3 : NRD + NTA + 1), "R2 R9 ready cycle", 32'(ready_k), 32'(wr ? NPULSE + 3 : NRD + NTA + 1));
    chk(done_n == 1, "R10 done pulses", 32'(done_n), 32'd1);
    chk(!bad_cs && fcs != 0, "R3 select pattern", {28'd0, m}, {28'd0, m});
    chk(!bad_addr, "R5 address during access", {11'd0, a}, {11'd0, a});
    chk(!fight, "R8 drive only on writes", 32'(fight), 32'd0);
    if (wr) begin
      chk(we_low == NPULSE, "R4 WE low cycles", 32'(we_low), 32'(NPULSE));
      chk(fwe - fcs == 1 && lcs - lwe == 1, "R4 setup/hold cycles", 32'(fwe - fcs), 32'd1);
      chk(oe_low == 0 && !bad_dq, "R4 data and OE during write", 32'(oe_low), 32'd0);
      expm[a[7:0]] = merge(expm[a[7:0]], d, m);
    end else begin
      chk(we_low == 0 && oe_low == NRD, "R6 read strobes", 32'(oe_low), 32'(NRD));
      chk(rd === exp_rd, "R6 read data", rd, exp_rd);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin ram[i] = '0; expm[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done,
        "R1 reset outputs", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done, req_ready},
        {4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && mem_cs_n == 4'hF && !mem_dq_oe, "R1 idle after reset",
        {31'd0, req_ready}, 32'd1);

    // Full word, then read immediately (write then read) and write right after read (R7)
    access(1, 21'h1FFF05, 32'hDEADBEEF, 4'hF);
    access(0, 21'h1FFF05, 32'h0, 4'hF);
    access(1, 21'h000006, 32'h01234567, 4'hF);

    // Per-lane writes over one word (R3)
    for (int i = 0; i < 4; i++)
      access(1, 21'h000010, {4{8'(8'h11 * (i + 1))}}, 4'(1 << i));
    access(0, 21'h000010, 32'h0, 4'hF);

    // Partial read: unselected bytes zero (R6)
    access(0, 21'h1FFF05, 32'h0, 4'b0101);
    access(0, 21'h1FFF05, 32'h0, 4'b1000);

    // Partial write preserves neighbours
    access(1, 21'h1FFF05, 32'hCAFE0000, 4'b1100);
    access(0, 21'h1FFF05, 32'h0, 4'hF);

    // Random mix
    for (int n = 0; n < 60; n++) begin
      logic [3:0] m;
      m = 4'($urandom_range(1, 15));
      access(1'($urandom_range(0, 1)), 21'($urandom), $urandom, m);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule